// File: doc/BRIEF.md
# Framed Serial Sample Output Port

This block sends a frame of signed 16-bit sample words, one per channel, to an external receiver. It is the serial master: it makes its own bit clock, a data line and a frame-start pulse. The bit clock is derived from the master clock by a fixed division. A rate-select input picks a divide ratio of 8 or 4 for the whole frame. Between frames the bit clock rests low.

A host loads all channel words in parallel on a flat input vector and pulses a start strobe. The port then drives one bit period with the frame pulse high. After that it sends every word, channel 0 first and most significant bit first, with no gaps. The data and frame lines change only while the bit clock is low, so a receiver samples them on the rising edge. A busy flag covers the transfer. A sticky overrun flag reports a start that arrived while a frame was still going out.

An enable input controls three separate output-enable lines, one for each serial pin. When the enable drops during a frame, the frame is abandoned and the port goes back to idle.

Top module: `sfo_port`

## Requirements
- R1: After reset, busy_o, overrun_o, sclk_o, sdo_o and fso_o are all low.
- R2: During a frame, one bit period lasts 8 master-clock cycles when rate_fast_i was low at the accepted start, and 4 cycles when it was high. Within each bit period, sclk_o is low for the first half and high for the second half.
- R3: rate_fast_i is sampled only when a start is accepted. Changing it during a frame does not alter the bit period of that frame.
- R4: fso_o is high for exactly the first bit period after an accepted start, and low for every later bit period of the frame.
- R5: After the frame pulse come 96 data bits with no gap: six 16-bit words in ascending channel order. Channel k is words_i[16k+15:16k]. Each word is sent MSB first, exactly as loaded (two's complement).
- R6: sdo_o and fso_o change only while sclk_o is low. Both hold their value through the whole high phase of sclk_o.
- R7: sclk_o is low whenever no frame is in progress. Once the last data bit's period ends, sclk_o stays low and busy_o falls.
- R8: sclk_oe_o, sdo_oe_o and fso_oe_o follow en_i. A start strobe while en_i is low is ignored.
- R9: If en_i falls during a frame, busy_o is low from the next cycle and sclk_o stays low. A later start sends a complete frame.
- R10: A start strobe while busy_o is high does not disturb the frame in progress, and it sets overrun_o. overrun_o stays set until the next accepted start clears it.
- R11: busy_o goes high in the cycle after an accepted start and stays high until the frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Output enable; abort when dropped mid-frame |
| rate_fast_i | input | 1 | Bit-rate select: 0 = clock/8, 1 = clock/4 |
| start_i | input | 1 | Start strobe, one cycle |
| words_i | input | 96 | Six channel words, channel k at bits 16k+15:16k |
| busy_o | output | 1 | Frame in progress |
| overrun_o | output | 1 | Sticky: start seen while busy |
| sclk_o | output | 1 | Bit clock |
| sclk_oe_o | output | 1 | Output enable for sclk_o |
| sdo_o | output | 1 | Serial data |
| sdo_oe_o | output | 1 | Output enable for sdo_o |
| fso_o | output | 1 | Frame-start pulse |
| fso_oe_o | output | 1 | Output enable for fso_o |

## Verification
The hardest situations to reach from the ports are disturbances in the middle of a frame: a second start strobe, a change of rate select, or a drop of the enable. Each must land partway through the 97 bit periods and must not corrupt the frame. The stimulus follows the bit clock edge by edge. It injects the disturbance once a chosen number of rising edges have been counted. It then checks the bit timing and the recovered words against the words loaded at the accepted start.

// File: rtl/sfo_pkg.sv
package sfo_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYNC = 2'd1,
    ST_DATA = 2'd2
  } sfo_state_e;
endpackage

// File: rtl/sfo_clkgen.sv
module sfo_clkgen #(
  parameter int SLOW_DIV = 8,
  parameter int FAST_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  input  logic fast_i,
  output logic slot_end_o,
  output logic sclk_o
);
  localparam int PH_W = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam logic [PH_W-1:0] SLOW_LAST = PH_W'(SLOW_DIV - 1);
  localparam logic [PH_W-1:0] FAST_LAST = PH_W'(FAST_DIV - 1);
  localparam logic [PH_W-1:0] SLOW_HALF = PH_W'(SLOW_DIV / 2);
  localparam logic [PH_W-1:0] FAST_HALF = PH_W'(FAST_DIV / 2);

  logic [PH_W-1:0] ph_q;
  logic            fast_q;
  logic [PH_W-1:0] last_ph, half_ph;

  assign last_ph = fast_q ? FAST_LAST : SLOW_LAST;
  assign half_ph = fast_q ? FAST_HALF : SLOW_HALF;

  // rate is frozen for the whole frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        fast_q <= 1'b0;
    else if (restart_i) fast_q <= fast_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ph_q <= '0;
    else if (restart_i || !run_i) ph_q <= '0;
    else if (ph_q == last_ph)    ph_q <= '0;
    else                         ph_q <= ph_q + 1'b1;
  end

  assign slot_end_o = run_i && (ph_q == last_ph);
  assign sclk_o     = run_i && (ph_q >= half_ph);
endmodule

// File: rtl/sfo_shifter.sv
module sfo_shifter #(
  parameter int NUM_CH = 6,
  parameter int WORD_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic                     shift_i,
  input  logic [NUM_CH*WORD_W-1:0] words_i,
  output logic                     msb_o
);
  localparam int TOT_W = NUM_CH * WORD_W;

  logic [TOT_W-1:0] load_vec;
  logic [TOT_W-1:0] sr_q;

  // channel 0 lands in the top word so it leaves first
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_order
    assign load_vec[(NUM_CH-1-ch)*WORD_W +: WORD_W] = words_i[ch*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sr_q <= '0;
    else if (load_i)   sr_q <= load_vec;
    else if (shift_i)  sr_q <= {sr_q[TOT_W-2:0], 1'b0};
  end

  assign msb_o = sr_q[TOT_W-1];
endmodule

// File: rtl/sfo_ctrl.sv
module sfo_ctrl
  import sfo_pkg::*;
#(
  parameter int DATA_BITS = 96
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       start_i,
  input  logic       slot_end_i,
  output sfo_state_e state_o,
  output logic       accept_o,
  output logic       shift_o,
  output logic       overrun_o
);
  localparam int CNT_W = $clog2(DATA_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_BITS - 1);

  sfo_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovr_q;
  logic             busy;

  assign busy     = (state_q != ST_IDLE);
  assign accept_o = start_i && en_i && !busy;
  assign shift_o  = (state_q == ST_DATA) && slot_end_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (!en_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept_o) begin
          state_q <= ST_SYNC;
          cnt_q   <= '0;
        end
        ST_SYNC: if (slot_end_i) state_q <= ST_DATA;
        ST_DATA: if (slot_end_i) begin
          if (cnt_q == LAST_BIT) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ovr_q <= 1'b0;
    else if (start_i && en_i && busy)     ovr_q <= 1'b1;
    else if (accept_o)                    ovr_q <= 1'b0;
  end

  assign state_o   = state_q;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/sfo_port.sv
module sfo_port
  import sfo_pkg::*;
#(
  parameter int NUM_CH   = 6,
  parameter int WORD_W   = 16,
  parameter int SLOW_DIV = 8,
  parameter int FAST_DIV = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     rate_fast_i,
  input  logic                     start_i,
  input  logic [NUM_CH*WORD_W-1:0] words_i,
  output logic                     busy_o,
  output logic                     overrun_o,
  output logic                     sclk_o,
  output logic                     sclk_oe_o,
  output logic                     sdo_o,
  output logic                     sdo_oe_o,
  output logic                     fso_o,
  output logic                     fso_oe_o
);
  localparam int DATA_BITS = NUM_CH * WORD_W;

  sfo_state_e state;
  logic       accept, shift, slot_end, msb, sclk_raw;

  sfo_ctrl #(.DATA_BITS(DATA_BITS)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .start_i    (start_i),
    .slot_end_i (slot_end),
    .state_o    (state),
    .accept_o   (accept),
    .shift_o    (shift),
    .overrun_o  (overrun_o)
  );

  sfo_clkgen #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_clkgen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (busy_o),
    .restart_i  (accept),
    .fast_i     (rate_fast_i),
    .slot_end_o (slot_end),
    .sclk_o     (sclk_raw)
  );

  sfo_shifter #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .shift_i (shift),
    .words_i (words_i),
    .msb_o   (msb)
  );

  assign busy_o    = (state != ST_IDLE);
  assign sclk_o    = sclk_raw;
  assign sdo_o     = (state == ST_DATA) && msb;
  assign fso_o     = (state == ST_SYNC);
  assign sclk_oe_o = en_i;
  assign sdo_oe_o  = en_i;
  assign fso_oe_o  = en_i;
endmodule

// File: rtl/sfo_port_chk.sv
module sfo_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic start_i,
  input logic busy_o,
  input logic overrun_o,
  input logic sclk_o,
  input logic sdo_o,
  input logic fso_o
);
  // R9
  abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !busy_o);

  // R10
  overrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && en_i) |=> overrun_o);

  // R11
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && en_i) |=> (busy_o && !overrun_o));

  // R6
  sdo_change_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !$stable(sdo_o)) |-> !sclk_o);

  // R6
  fso_change_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fso_o) |-> !sclk_o);

  // R7
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> busy_o);
endmodule

bind sfo_port sfo_port_chk u_chk (.*);

// File: tb/sfo_port_tb_top.sv
module sfo_port_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b1;
  logic        rate_fast_i = 1'b0;
  logic        start_i = 1'b0;
  logic [95:0] words_i = '0;
  logic busy_o, overrun_o, sclk_o, sclk_oe_o, sdo_o, sdo_oe_o, fso_o, fso_oe_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk_i = ~clk_i;

  sfo_port dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .rate_fast_i(rate_fast_i),
    .start_i(start_i), .words_i(words_i), .busy_o(busy_o), .overrun_o(overrun_o),
    .sclk_o(sclk_o), .sclk_oe_o(sclk_oe_o), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
    .fso_o(fso_o), .fso_oe_o(fso_oe_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drives one frame and decodes it edge by edge
  task automatic run_frame(input logic [95:0] w, input bit fast,
                           input bit flip_mode, input bit inject);
    int bits = 0, fso_err = 0, dat_err = 0, per_err = 0, stab_err = 0, since = 0;
    int div = fast ? 4 : 8;
    bit prev, ov_seen = 0;
    logic sdo_at = 0, fso_at = 0;
    @(negedge clk_i);
    words_i = w; rate_fast_i = fast; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R11", "busy after start", busy_o, 1);
    check(overrun_o == 1'b0, "R10", "overrun cleared by start", overrun_o, 0);
    prev = sclk_o;
    since = 1;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      if (sclk_o && !prev) begin
        if (bits > 0 && since != div) per_err++;
        sdo_at = sdo_o; fso_at = fso_o;
        if (fso_o != (bits == 0)) fso_err++;
        if (bits > 0) begin
          int idx = bits - 1;
          int ch = idx / 16;
          int b = 15 - (idx % 16);
          if (sdo_o != w[ch*16 + b]) dat_err++;
        end
        bits++;
        since = 0;
      end else if (sclk_o && prev) begin
        if (sdo_o != sdo_at || fso_o != fso_at) stab_err++;
      end
      if (flip_mode && bits == 5) rate_fast_i = !fast;
      if (inject && bits == 10 && !start_i && !ov_seen) begin
        words_i = ~w; start_i = 1'b1;
      end else if (start_i) begin
        start_i = 1'b0; ov_seen = 1;
        check(overrun_o == 1'b1, "R10", "overrun after start while busy", overrun_o, 1);
        check(busy_o == 1'b1, "R10", "frame continues after extra start", busy_o, 1);
      end
      prev = sclk_o;
      since++;
      if (!busy_o) break;
      @(negedge clk_i);
    end
    check(bits == 97, "R5", "bit periods in frame", bits, 97);
    check(fso_err == 0, "R4", "frame pulse placement errors", fso_err, 0);
    check(dat_err == 0, "R5", "data bit errors", dat_err, 0);
    check(per_err == 0, flip_mode ? "R3" : "R2", "bit period errors", per_err, 0);
    check(stab_err == 0, "R6", "changes while sclk high", stab_err, 0);
    check(sclk_o == 1'b0 && busy_o == 1'b0, "R7", "sclk/busy after frame",
          {sclk_o, busy_o}, 0);
    if (inject) check(ov_seen, "R10", "extra start injected", ov_seen, 1);
    repeat (5) begin
      @(negedge clk_i);
      check(sclk_o == 1'b0 && fso_o == 1'b0, "R7", "idle sclk/fso", {sclk_o, fso_o}, 0);
    end
    rate_fast_i = 1'b0;
  endtask

  task automatic test_reset();
    check(busy_o == 0 && overrun_o == 0, "R1", "reset busy/overrun", {busy_o, overrun_o}, 0);
    check(sclk_o == 0 && sdo_o == 0 && fso_o == 0, "R1", "reset serial lines",
          {sclk_o, sdo_o, fso_o}, 0);
    check({sclk_oe_o, sdo_oe_o, fso_oe_o} == 3'b111, "R8", "oe with enable high",
          {sclk_oe_o, sdo_oe_o, fso_oe_o}, 7);
  endtask

  task automatic test_abort();
    @(negedge clk_i);
    words_i = {16'h8000, 16'h7fff, 16'hffff, 16'h0001, 16'h5a5a, 16'hc3c3};
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (40) @(negedge clk_i);
    check(busy_o == 1'b1, "R11", "busy mid-frame", busy_o, 1);
    en_i = 1'b0;
    #0;
    check({sclk_oe_o, sdo_oe_o, fso_oe_o} == 3'b000, "R8", "oe with enable low",
          {sclk_oe_o, sdo_oe_o, fso_oe_o}, 0);
    @(negedge clk_i);
    check(busy_o == 1'b0 && sclk_o == 1'b0, "R9", "abort to idle", {busy_o, sclk_o}, 0);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    check(busy_o == 1'b0, "R8", "start ignored while disabled", busy_o, 0);
    en_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check(busy_o == 1'b0 && sclk_o == 1'b0, "R9", "stays idle after re-enable",
          {busy_o, sclk_o}, 0);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++; n_tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    test_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    test_reset();
    run_frame({16'h1234, 16'hfedc, 16'h8001, 16'h7ffe, 16'h0f0f, 16'ha5c3}, 1'b0, 1'b0, 1'b0);
    run_frame({16'h0000, 16'hffff, 16'h8000, 16'h7fff, 16'h0001, 16'h8ace}, 1'b1, 1'b0, 1'b0);
    run_frame({16'h3c3c, 16'h9999, 16'h0246, 16'hbdf1, 16'h1357, 16'he001}, 1'b0, 1'b1, 1'b1);
    run_frame({16'h6b2d, 16'h41a0, 16'hd00d, 16'h0c35, 16'h7777, 16'h8888}, 1'b1, 1'b1, 1'b0);
    test_abort();
    run_frame({16'hcafe, 16'h1b2c, 16'h3d4e, 16'h5f60, 16'h7182, 16'h93a4}, 1'b1, 1'b0, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule